// File: doc/BRIEF.md
# Bit-Clock to Frame-Clock Ratio Detector with Stop Reset

This block sits at the edge of a slave-mode serial audio port. It counts bit-clock cycles between successive rising edges of the frame clock. It reports which of nine supported bit-clocks-per-frame ratios is present and raises a valid flag when that ratio is usable for the configured output format. Two-channel formats accept ratios only up to 256. The time-division format accepts all nine.

A separate low-speed reference clock watches the bit clock for activity. When the bit clock stays idle for a compile-time number of reference cycles, the block asserts an internal reset at once. The rest of the device is held in reset until the bit clock runs again, and the reset is released in step with the bit clock. The output format select is captured once, on the first bit-clock edge after that release. Stopping the bit clock is therefore the only way to apply a new format.

Top module: `clk_ratio_detector`

## Requirements
- R1: Ratio codes on `ratio_o` are 0=32, 1=48, 2=64, 3=96, 4=128, 5=192, 6=256, 7=384 and 8=512 bit clocks per frame. Code 15 means no ratio is locked, and in that case `valid_o` is 0.
- R2: A frame edge is a rising edge of `frame_i` sampled on a rising edge of `bclk_i`. A ratio locks only when two consecutive frame periods measure the same listed count. Outputs update on the bit-clock edge that samples the frame edge closing the second period.
- R3: A measured period that matches no listed ratio clears the lock on the edge that closes that period, so `ratio_o` becomes 15 and `valid_o` becomes 0.
- R4: A single period of a different listed ratio leaves the current lock unchanged. A second consecutive period of that ratio switches to it.
- R5: For format codes 0, 1 and 2 (two-channel), `valid_o` is 0 for ratios 384 and 512 while `ratio_o` still reports them. For code 3 (time-division), every listed ratio is valid.
- R6: `fmt_i` is captured only on the first bit-clock edge after the internal reset releases. Later changes have no effect until the next stop.
- R7: If no frame edge arrives within 1024 bit clocks of the last one, the lock clears on the 1024th rising edge.
- R8: When `bclk_i` stays idle for STOP_TICKS reference-clock cycles, `core_rst_no` goes low without waiting for a bit-clock edge, and `ratio_o` and `valid_o` return to 15 and 0.
- R9: `core_rst_no` stays low while the bit clock is stopped. It rises only on a rising edge of `bclk_i`, a few reference cycles after the bit clock resumes.
- R10: While `rst_ni` is low, `core_rst_no` is low. After `rst_ni` rises, `core_rst_no` stays low until bit-clock activity is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock |
| frame_i | input | 1 | Frame clock or frame sync, sampled on bit-clock rising edges |
| ref_clk_i | input | 1 | Free-running low-speed reference clock for stop detection |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| fmt_i | input | 2 | Output format: 0 two-channel stereo, 1 two mono sources, 2 left-justified, 3 time-division |
| ratio_o | output | 4 | Locked ratio code, 15 when none is locked |
| valid_o | output | 1 | Locked ratio is allowed for the captured format |
| core_rst_no | output | 1 | Active-low internal reset, released in the bit-clock domain |

## Verification
Lock, unlock and timeout results appear on the bit-clock rising edge that samples the deciding frame edge, or the 1024th idle edge. A behavioural model in the bench advances on each rising edge and is compared on each falling edge, so every such result is checked exactly one half-period after it is due. Stop detection and reset release cross between the two clock domains, so their timing depends on the phase of the reference clock. Those checks therefore use windows counted in reference cycles: a point safely before the earliest possible assertion, and a point after the latest. The release edge itself is checked against the level of the bit clock at the moment of release.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
  localparam int NUM_RATIOS  = 9;
  localparam int BASE_RATIO  = 32;
  localparam int TWO_CH_MAX  = 256;
  localparam int CODE_W      = 4;
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  typedef enum logic [1:0] {
    FMT_STEREO = 2'd0,
    FMT_MONO2  = 2'd1,
    FMT_LEFTJ  = 2'd2,
    FMT_TDM    = 2'd3
  } fmt_e;

  // even index: 32*2^(i/2), odd index: 48*2^(i/2)
  function automatic int ratio_of(input int idx);
    if (idx % 2 == 0) return BASE_RATIO << (idx / 2);
    else              return (BASE_RATIO * 3 / 2) << (idx / 2);
  endfunction
endpackage

// File: rtl/bclk_stop_det.sv
module bclk_stop_det #(
  parameter int STOP_TICKS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic bclk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic stopped_o
);
  localparam int SW = $clog2(STOP_TICKS + 1);

  logic                 tog_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 activity;
  logic [SW-1:0]        idle_q;
  logic                 stopped_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
  end

  assign activity = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q    <= '0;
      stopped_q <= 1'b1;
    end else if (activity) begin
      idle_q    <= '0;
      stopped_q <= 1'b0;
    end else begin
      if (idle_q != SW'(STOP_TICKS)) idle_q <= idle_q + 1'b1;
      if (idle_q == SW'(STOP_TICKS - 1)) stopped_q <= 1'b1;
    end
  end

  assign stopped_o = stopped_q;

  assert_idle_bound_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    idle_q <= SW'(STOP_TICKS));
  assert_stop_after_idle_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> $past(idle_q) == SW'(STOP_TICKS - 1));
  assert_wake_on_activity_R9: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(stopped_q) |-> $past(activity));
endmodule

// File: rtl/core_rst_sync.sv
module core_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stopped_i,
  output logic rst_no
);
  logic              arst_n;
  logic [STAGES-1:0] q;

  assign arst_n = rst_ni & ~stopped_i;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
  parameter int SAT = 1024,
  parameter int CW  = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  output logic          meas_vld_o,
  output logic [CW-1:0] meas_o,
  output logic          timeout_o
);
  logic          frame_d;
  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          edge_now;

  assign edge_now = frame_i & ~frame_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_d <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_d <= frame_i;
      if (edge_now) begin
        seen_q <= 1'b1;
        cnt_q  <= '0;
      end else if (cnt_q != CW'(SAT)) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign meas_vld_o = edge_now & seen_q;
  assign meas_o     = cnt_q + 1'b1;
  assign timeout_o  = ~edge_now & (cnt_q == CW'(SAT - 1));

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SAT));
  assert_edge_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_now |=> cnt_q == '0);
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import ratio_det_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              meas_vld_i,
  input  logic [CW-1:0]     meas_i,
  input  logic              timeout_i,
  output logic [CODE_W-1:0] ratio_o,
  output logic              valid_o
);
  localparam int NCODES = 1 << CODE_W;

  logic [NUM_RATIOS-1:0] hit;
  logic [NCODES-1:0]     cap_ok;
  logic [CODE_W-1:0]     enc;
  logic                  hit_any;

  fmt_e              cfg_q;
  logic              loaded_q;
  logic [CW-1:0]     prev_q;
  logic              have_prev_q;
  logic              locked_q;
  logic [CODE_W-1:0] code_q;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_cmp
    assign hit[g] = (meas_i == CW'(ratio_of(g)));
  end

  for (genvar g = 0; g < NCODES; g++) begin : g_cap
    if (g < NUM_RATIOS) begin : g_real
      assign cap_ok[g] = (ratio_of(g) <= TWO_CH_MAX);
    end else begin : g_pad
      assign cap_ok[g] = 1'b0;
    end
  end

  always_comb begin
    enc = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) enc = CODE_W'(i);
    end
  end

  assign hit_any = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= FMT_STEREO;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      cfg_q    <= fmt_e'(fmt_i);
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      locked_q    <= 1'b0;
      code_q      <= CODE_NONE;
    end else if (meas_vld_i) begin
      prev_q      <= meas_i;
      have_prev_q <= 1'b1;
      if (!hit_any) begin
        locked_q <= 1'b0;
      end else if (have_prev_q && prev_q == meas_i) begin
        locked_q <= 1'b1;
        code_q   <= enc;
      end
    end else if (timeout_i) begin
      locked_q    <= 1'b0;
      have_prev_q <= 1'b0;
    end
  end

  assign ratio_o = locked_q ? code_q : CODE_NONE;
  assign valid_o = locked_q & ((cfg_q == FMT_TDM) | cap_ok[code_q]);

  assert_lock_needs_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(meas_vld_i && have_prev_q));
  assert_unmatched_unlocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && !hit_any) |=> !locked_q);
  assert_cfg_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(loaded_q) |-> $stable(cfg_q));
  assert_timeout_unlocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> !locked_q);
endmodule

// File: rtl/clk_ratio_detector.sv
module clk_ratio_detector
  import ratio_det_pkg::*;
#(
  parameter int STOP_TICKS  = 100,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              bclk_i,
  input  logic              frame_i,
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  output logic [CODE_W-1:0] ratio_o,
  output logic              valid_o,
  output logic              core_rst_no
);
  localparam int MAX_RATIO = ratio_of(NUM_RATIOS - 1);
  localparam int SAT       = 2 * MAX_RATIO;
  localparam int CW        = $clog2(SAT + 2);

  logic          stopped;
  logic          core_rst_n;
  logic          meas_vld;
  logic [CW-1:0] meas;
  logic          timeout;

  bclk_stop_det #(.STOP_TICKS(STOP_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_stop (
    .bclk_i    (bclk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .stopped_o (stopped)
  );

  core_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i     (bclk_i),
    .rst_ni    (rst_ni),
    .stopped_i (stopped),
    .rst_no    (core_rst_n)
  );

  frame_period_meter #(.SAT(SAT), .CW(CW)) u_meter (
    .clk_i      (bclk_i),
    .rst_ni     (core_rst_n),
    .frame_i    (frame_i),
    .meas_vld_o (meas_vld),
    .meas_o     (meas),
    .timeout_o  (timeout)
  );

  ratio_classifier #(.CW(CW)) u_class (
    .clk_i      (bclk_i),
    .rst_ni     (core_rst_n),
    .fmt_i      (fmt_i),
    .meas_vld_i (meas_vld),
    .meas_i     (meas),
    .timeout_i  (timeout),
    .ratio_o    (ratio_o),
    .valid_o    (valid_o)
  );

  assign core_rst_no = core_rst_n;
endmodule

// File: tb/clk_ratio_detector_test.sv
module clk_ratio_detector_test;
  localparam int STOP_TICKS = 16;
  localparam int SAT        = 1024;

  logic       bclk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       run = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [1:0] fmt_i = 2'd0;
  logic [3:0] ratio_o;
  logic       valid_o;
  logic       core_rst_no;

  int    n_chk = 0;
  int    n_err = 0;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R2";

  clk_ratio_detector #(.STOP_TICKS(STOP_TICKS)) uut (
    .bclk_i      (bclk),
    .frame_i     (frame_i),
    .ref_clk_i   (ref_clk),
    .rst_ni      (rst_ni),
    .fmt_i       (fmt_i),
    .ratio_o     (ratio_o),
    .valid_o     (valid_o),
    .core_rst_no (core_rst_no)
  );

  // 50 MHz bit clock, gated by run; 10 MHz reference
  always begin
    #10;
    if (run) bclk = ~bclk;
    else     bclk = 1'b0;
  end
  always #50 ref_clk = ~ref_clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_val(input int k);
    return (k % 2 == 0) ? (32 << (k / 2)) : (48 << (k / 2));
  endfunction

  function automatic int ratio_index(input int n);
    for (int k = 0; k < 9; k++) if (ratio_val(k) == n) return k;
    return -1;
  endfunction

  // behavioural reference model
  int m_since, m_prev, m_code, m_cfg;
  bit m_seen, m_fprev, m_loaded, m_have, m_locked;

  always @(posedge bclk) begin
    if (!core_rst_no) begin
      m_since = 0; m_prev = 0; m_code = 15; m_cfg = 0;
      m_seen = 0; m_fprev = 0; m_loaded = 0; m_have = 0; m_locked = 0;
    end else begin
      bit e;
      if (!m_loaded) begin m_cfg = fmt_i; m_loaded = 1; end
      e = frame_i && !m_fprev;
      m_fprev = frame_i;
      if (e) begin
        if (m_seen) begin
          int meas, idx;
          meas = m_since + 1;
          idx = ratio_index(meas);
          if (idx < 0) m_locked = 0;
          else if (m_have && m_prev == meas) begin m_locked = 1; m_code = idx; end
          m_prev = meas;
          m_have = 1;
        end
        m_seen = 1;
        m_since = 0;
      end else begin
        if (m_since == SAT - 1) begin m_locked = 0; m_have = 0; end
        if (m_since < SAT) m_since++;
      end
    end
  end

  always @(negedge bclk) begin
    if (cmp_en) begin
      int er, ev;
      er = m_locked ? m_code : 15;
      ev = (m_locked && (m_cfg == 3 || m_code <= 6)) ? 1 : 0;
      check(cur_req, int'(ratio_o), er);
      check(cur_req, int'(valid_o), ev);
    end
  end

  // R9: release happens on a bit-clock rising edge
  always @(posedge core_rst_no) begin
    if (run) check("R9 release on bclk rise", int'(bclk), 1);
  end

  task automatic frames(input int ratio, input int n, input bit wide);
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < ratio; c++) begin
        @(negedge bclk);
        frame_i = wide ? (c < ratio / 2) : (c == 0);
      end
    end
  endtask

  task automatic ref_wait(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_clk);
    #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    // R10: power-on state, clock idle
    ref_wait(5);
    check("R10 reset low", int'(core_rst_no), 0);
    check("R1 no lock code", int'(ratio_o), 15);
    check("R1 valid low", int'(valid_o), 0);
    rst_ni = 1'b1;
    ref_wait(30);
    check("R10 held without bclk", int'(core_rst_no), 0);
    run = 1'b1;
    ref_wait(10);
    check("R10 released after bclk", int'(core_rst_no), 1);
    @(negedge bclk);
    cmp_en = 1'b1;

    // R2: lock needs two equal periods
    cur_req = "R2";
    frames(64, 2, 0);
    check("R2 one period not locked", int'(ratio_o), 15);
    frames(64, 2, 0);
    check("R2 locked 64", int'(ratio_o), 2);
    check("R2 valid 64", int'(valid_o), 1);

    // R4: single different period holds lock
    cur_req = "R4";
    frames(128, 2, 1);
    check("R4 held on single 128", int'(ratio_o), 2);
    frames(128, 1, 1);
    check("R4 switched to 128", int'(ratio_o), 4);

    // R3: unmatched count clears lock
    cur_req = "R3";
    frames(100, 2, 0);
    check("R3 unmatched ratio code", int'(ratio_o), 15);
    check("R3 unmatched valid", int'(valid_o), 0);

    // R1 and R5: every ratio, two-channel cap
    cur_req = "R1";
    for (int k = 0; k < 9; k++) begin
      frames(ratio_val(k), 3, k[0]);
      check("R1 code", int'(ratio_o), k);
      check("R5 two-channel cap", int'(valid_o), (k <= 6) ? 1 : 0);
    end

    // R6: format change while running is ignored
    cur_req = "R6";
    fmt_i = 2'd3;
    frames(384, 3, 0);
    check("R6 code 384", int'(ratio_o), 7);
    check("R6 late format ignored", int'(valid_o), 0);

    // R7: frame clock absent
    cur_req = "R7";
    frame_i = 1'b0;
    repeat (600) @(negedge bclk);
    check("R7 still locked", int'(ratio_o), 7);
    repeat (60) @(negedge bclk);
    check("R7 timeout code", int'(ratio_o), 15);

    cur_req = "R5";
    fmt_i = 2'd0;
    frames(256, 3, 1);
    check("R5 256 allowed two-channel", int'(valid_o), 1);
    check("R1 code 256", int'(ratio_o), 6);

    // R8: stop the bit clock
    fmt_i = 2'd3;
    cmp_en = 1'b0;
    @(negedge bclk);
    run = 1'b0;
    ref_wait(STOP_TICKS - 2);
    check("R8 not early", int'(core_rst_no), 1);
    ref_wait(8);
    check("R8 reset asserted", int'(core_rst_no), 0);
    check("R8 ratio cleared", int'(ratio_o), 15);
    check("R8 valid cleared", int'(valid_o), 0);
    ref_wait(20);
    check("R9 held while stopped", int'(core_rst_no), 0);

    // R9: restart, then R6 new format taken
    run = 1'b1;
    ref_wait(10);
    check("R9 released after restart", int'(core_rst_no), 1);
    repeat (4) @(negedge bclk);
    cmp_en = 1'b1;
    cur_req = "R6";
    frames(512, 3, 0);
    check("R6 code 512", int'(ratio_o), 8);
    check("R6 new format applied", int'(valid_o), 1);
    cmp_en = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule